// File: doc/BRIEF.md
# Serial DAC Write Master

This block sits on the host side of a three-wire serial link to a voltage-output DAC and performs one write per request. A request carries a 12-bit output code, a 2-bit operating-mode field and a byte-split flag, and it is taken through a valid/ready handshake. The block packs these into a 16-bit word and clocks it out MSB first on a frame-select line (active low), a serial clock and a serial data line. All link timing comes from the system clock: the high and low phases of the serial clock, the setup time from frame start to the first clock, the pause in the middle of a byte-split frame, and the minimum time the frame line stays high between writes.

The serial clock idles low. Data changes only on its rising edges, so the slave can take each bit on the falling edge. When the last bit has been taken, the frame line goes high. A completion pulse then reports whether the write ran to the end or was cut short. An abort request raises the frame line before the sixteenth falling edge, and the slave then throws the partial word away. Byte-split mode sends the word as two bursts of eight clocks, with the frame line held low across the pause between them. This suits hosts that can only produce 8-bit bursts.

Top module: `dac_wr_master`

## Requirements
- R1: While reset is high and right after it is released: the frame line is high, the serial clock and data are low, ready is high, and done and its aborted flag are low.
- R2: The word sent for a normal write is, MSB first: two zero bits, then the mode field (2 bits), then the code (12 bits, MSB first). Each bit is taken as the value on the data line just before a falling edge of the serial clock.
- R3: The serial clock is low when the frame line falls. While the frame line stays low, the data line changes only in the cycle where the serial clock rises. The first rising edge comes at least SETUP_CLKS system cycles after the frame line falls.
- R4: A normal write has exactly 16 falling edges of the serial clock while the frame line is low. Every high phase inside a burst, and every low phase between bursts, lasts HALF_DIV system cycles. The parameters must keep each phase at 13 ns or more and the rate at 30 MHz or less.
- R5: In byte-split mode the clock stays low for BURST_GAP_CLKS cycles after the eighth falling edge, with the frame line held low, and then the remaining eight edges follow. Without split, that low phase is HALF_DIV cycles.
- R6: An abort request during a frame raises the frame line on the next clock edge. The falling edges already produced are kept, and no more are produced inside the frame. Done is raised with its aborted flag at 1.
- R7: Done is a single-cycle pulse in the same cycle the frame line rises. The aborted flag is 0 when the write ran to its 16th edge.
- R8: Ready is low from the accepting cycle until the frame line has been high for GAP_CLKS cycles; it rises exactly GAP_CLKS cycles after done. Between frames the frame line stays high for at least GAP_CLKS cycles.
- R9: Whenever the frame line is high, the data line is low.
- R10: An abort request while no frame is in progress has no effect: the lines stay idle, no done pulse appears, and ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_code | input | 12 | Output code to send |
| req_mode | input | 2 | Operating-mode field to send |
| req_split | input | 1 | Send the word as two 8-clock bursts |
| abort_req | input | 1 | End the current frame early |
| ser_frame_n | output | 1 | Frame select, active low |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, changes on clock rise |
| done | output | 1 | One-cycle pulse at frame end |
| done_aborted | output | 1 | Qualifies done: 1 when the frame was aborted |

## Verification
All outputs are registered. The frame line falls one edge after a request is accepted. The first serial clock rise comes SETUP_CLKS edges later, and each phase after that lasts HALF_DIV edges. Done appears on the same edge as the final falling edge of the clock, and ready returns exactly GAP_CLKS edges after done. An abort takes effect on the first edge after it is seen. The bench runs a slave model that samples every line half a cycle after each active edge. It rebuilds the word from the falling edges, measures each phase length, setup time and gap in system cycles, and compares each against the parameter value it should equal. Abort is driven the half cycle after the chosen falling edge is seen, so the expected captured edge count is exactly that number.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_BGAP,
    ST_GAP
  } dacw_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/dacw_timer.sv
module dacw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dacw_shreg.sv
module dacw_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word_in,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (load)  word <= word_in;
    else if (shift) word <= {word[W-2:0], 1'b0};
  end

  assign msb = word[W-1];
endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
  import dacw_pkg::*;
#(
  parameter int FRAME_W        = 16,
  parameter int HALF_DIV       = 2,
  parameter int SETUP_CLKS     = 1,
  parameter int GAP_CLKS       = 2,
  parameter int BURST_GAP_CLKS = 4,
  parameter int TW             = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_split,
  input  logic          abort_req,
  input  logic          tmr_zero,
  input  logic          bit_msb,
  output logic          req_ready,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          ser_frame_n,
  output logic          ser_clk,
  output logic          ser_data,
  output logic          done,
  output logic          done_aborted
);
  localparam int EW = $clog2(FRAME_W + 1);
  localparam logic [EW-1:0] LAST_EDGE  = EW'(FRAME_W - 1);
  localparam logic [EW-1:0] SPLIT_EDGE = EW'(FRAME_W / 2 - 1);
  localparam logic [TW-1:0] V_HALF  = TW'(HALF_DIV - 1);
  localparam logic [TW-1:0] V_SETUP = TW'(SETUP_CLKS - 1);
  localparam logic [TW-1:0] V_GAP   = TW'(GAP_CLKS - 1);
  localparam logic [TW-1:0] V_BGAP  = TW'(BURST_GAP_CLKS - 1);

  dacw_state_e   st;
  logic [EW-1:0] edges;
  logic          split_q;
  logic          in_frame, accept, abort_now, rise_now, fall_now, last_fall, split_fall;

  assign req_ready  = (st == ST_IDLE);
  assign in_frame   = (st == ST_SETUP) || (st == ST_HIGH) || (st == ST_LOW) || (st == ST_BGAP);
  assign accept     = req_ready && req_valid;
  assign abort_now  = in_frame && abort_req;
  assign rise_now   = !abort_now && tmr_zero &&
                      ((st == ST_SETUP) || (st == ST_LOW) || (st == ST_BGAP));
  assign fall_now   = !abort_now && tmr_zero && (st == ST_HIGH);
  assign last_fall  = fall_now && (edges == LAST_EDGE);
  assign split_fall = fall_now && split_q && (edges == SPLIT_EDGE);
  assign sh_load    = accept;
  assign sh_shift   = rise_now;

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = V_HALF;
    if (accept)          tmr_val = V_SETUP;
    else if (abort_now)  tmr_val = V_GAP;
    else if (rise_now)   tmr_val = V_HALF;
    else if (last_fall)  tmr_val = V_GAP;
    else if (split_fall) tmr_val = V_BGAP;
    else if (fall_now)   tmr_val = V_HALF;
    else                 tmr_load = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      edges        <= '0;
      split_q      <= 1'b0;
      ser_frame_n  <= 1'b1;
      ser_clk      <= 1'b0;
      ser_data     <= 1'b0;
      done         <= 1'b0;
      done_aborted <= 1'b0;
    end else begin
      done         <= 1'b0;
      done_aborted <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st          <= ST_SETUP;
            edges       <= '0;
            split_q     <= req_split;
            ser_frame_n <= 1'b0;
            ser_data    <= 1'b0;
          end
        end
        ST_GAP: begin
          ser_clk <= 1'b0;
          if (tmr_zero) st <= ST_IDLE;
        end
        default: begin
          if (abort_now) begin
            st           <= ST_GAP;
            ser_frame_n  <= 1'b1;
            ser_data     <= 1'b0;
            done         <= 1'b1;
            done_aborted <= 1'b1;
          end else if (rise_now) begin
            st       <= ST_HIGH;
            ser_clk  <= 1'b1;
            ser_data <= bit_msb;
          end else if (fall_now) begin
            ser_clk <= 1'b0;
            edges   <= edges + 1'b1;
            if (last_fall) begin
              st          <= ST_GAP;
              ser_frame_n <= 1'b1;
              ser_data    <= 1'b0;
              done        <= 1'b1;
            end else if (split_fall) begin
              st <= ST_BGAP;
            end else begin
              st <= ST_LOW;
            end
          end
        end
      endcase
    end
  end

  assert_clk_low_at_frame_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_frame_n) |-> !ser_clk);

  assert_data_moves_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (!ser_frame_n && $past(!ser_frame_n) && !$stable(ser_data)) |-> $rose(ser_clk));

  assert_edge_bound_R4: assert property (@(posedge clk) disable iff (rst)
    edges <= EW'(FRAME_W));

  assert_done_with_frame_end_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(ser_frame_n));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !ser_frame_n |-> !req_ready);

  assert_data_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    ser_frame_n |-> !ser_data);
endmodule

// File: rtl/dac_wr_master.sv
module dac_wr_master
  import dacw_pkg::*;
#(
  parameter int SYS_MHZ        = 100,
  parameter int CODE_W         = 12,
  parameter int MODE_W         = 2,
  parameter int PAD_W          = 2,
  parameter int HALF_DIV       = 2,
  parameter int SETUP_CLKS     = 1,
  parameter int GAP_CLKS       = 2,
  parameter int BURST_GAP_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_split,
  input  logic              abort_req,
  output logic              ser_frame_n,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              done,
  output logic              done_aborted
);
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int MAXC    = max4(HALF_DIV, SETUP_CLKS, GAP_CLKS, BURST_GAP_CLKS);
  localparam int TW      = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic          tmr_load, tmr_zero, sh_load, sh_shift, bit_msb;
  logic [TW-1:0] tmr_val;
  logic [FRAME_W-1:0] frame_word;

  assign frame_word = {{PAD_W{1'b0}}, req_mode, req_code};

  initial begin
    assert_phase_width_R4: assert (HALF_DIV * 1000 >= 13 * SYS_MHZ)
      else $error("serial clock phase shorter than 13 ns");
    assert_clock_rate_R4: assert (SYS_MHZ <= 60 * HALF_DIV)
      else $error("serial clock above 30 MHz");
  end

  dacw_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  dacw_shreg #(.W(FRAME_W)) u_shreg (
    .clk(clk), .rst(rst), .load(sh_load), .word_in(frame_word),
    .shift(sh_shift), .msb(bit_msb)
  );

  dacw_ctrl #(
    .FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV), .SETUP_CLKS(SETUP_CLKS),
    .GAP_CLKS(GAP_CLKS), .BURST_GAP_CLKS(BURST_GAP_CLKS), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_split(req_split),
    .abort_req(abort_req), .tmr_zero(tmr_zero), .bit_msb(bit_msb),
    .req_ready(req_ready), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_shift(sh_shift), .ser_frame_n(ser_frame_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .done(done), .done_aborted(done_aborted)
  );
endmodule

// File: tb/dac_wr_master_tb.sv
module dac_wr_master_tb;
  localparam int HALF  = 2;
  localparam int SETUP = 2;
  localparam int GAP   = 3;
  localparam int BGAP  = 6;
  localparam int NV    = 10;
  // vector: {split, mode[1:0], code[11:0], abort_at[4:0]}; abort_at 31 = run to end
  localparam logic [19:0] VECS [NV] = '{
    {1'b0, 2'd0, 12'hABC, 5'd31},
    {1'b0, 2'd1, 12'h000, 5'd31},
    {1'b0, 2'd2, 12'hFFF, 5'd31},
    {1'b0, 2'd3, 12'h5A5, 5'd31},
    {1'b1, 2'd0, 12'h123, 5'd31},
    {1'b1, 2'd3, 12'hF0F, 5'd31},
    {1'b0, 2'd0, 12'h7FF, 5'd5},
    {1'b0, 2'd2, 12'hFFF, 5'd15},
    {1'b1, 2'd1, 12'hAAA, 5'd8},
    {1'b0, 2'd1, 12'h321, 5'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_split = 1'b0, abort_req = 1'b0;
  logic [11:0] req_code = '0;
  logic [1:0]  req_mode = '0;
  logic req_ready, ser_frame_n, ser_clk, ser_data, done, done_aborted;

  always #5 clk = ~clk;

  dac_wr_master #(
    .HALF_DIV(HALF), .SETUP_CLKS(SETUP), .GAP_CLKS(GAP), .BURST_GAP_CLKS(BGAP)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_mode(req_mode), .req_split(req_split),
    .abort_req(abort_req), .ser_frame_n(ser_frame_n), .ser_clk(ser_clk),
    .ser_data(ser_data), .done(done), .done_aborted(done_aborted)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and timing monitor, sampled half a cycle after each active edge
  logic p_clk = 1'b0, p_frame = 1'b1, p_data = 1'b0;
  logic is_rise, is_fall;
  logic [15:0] word = '0, last_word = '0;
  int falls = 0, setup_len = 0, hi_len = 0, low_len = 0, low8 = -1, gap_len = 1000;
  int seen_rise = 0, min_setup = 1000;
  int done_cnt = 0, last_falls = 0, last_ab = 0, last_low8 = -1;
  int viol_data = 0, viol_phase = 0, viol_ready = 0, viol_idle = 0, viol_gap = 0;

  always @(negedge clk) begin
    if (!rst) begin
      is_rise = ser_clk && !p_clk;
      is_fall = !ser_clk && p_clk;
      if (!ser_frame_n && p_frame) begin
        if (gap_len < GAP) viol_gap++;
        falls = 0; word = '0; setup_len = 1; seen_rise = 0; low8 = -1;
      end else if (!ser_frame_n) begin
        if (ser_data != p_data && !is_rise) viol_data++;
        if (is_rise) begin
          if (seen_rise == 0) begin
            seen_rise = 1;
            if (setup_len < min_setup) min_setup = setup_len;
          end else if (falls == 8) low8 = low_len;
          else if (low_len != HALF) viol_phase++;
          hi_len = 1;
        end else if (ser_clk) hi_len++;
        else if (seen_rise == 0) setup_len++;
        else if (!is_fall) low_len++;
      end
      if (is_fall && !p_frame) begin
        falls++;
        word = {word[14:0], p_data};
        if (hi_len != HALF) viol_phase++;
        low_len = 1;
      end
      if (ser_frame_n) begin
        gap_len++;
        if (ser_data) viol_idle++;
      end
      if (!ser_frame_n && req_ready) viol_ready++;
      if (done) begin
        done_cnt++;
        last_falls = falls; last_word = word; last_ab = int'(done_aborted);
        last_low8 = low8; gap_len = 1;
      end
      p_clk = ser_clk; p_frame = ser_frame_n; p_data = ser_data;
    end
  end

  task automatic run_vec(input logic [19:0] v);
    logic [15:0] exp_word;
    int ab, dc, wd, n;
    ab = int'(v[4:0]);
    exp_word = {2'b00, v[18:17], v[16:5]};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_split = v[19]; req_mode = v[18:17]; req_code = v[16:5];
    dc = done_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    wd = 0;
    while (done_cnt == dc && wd < 2000) begin
      @(negedge clk); #1;
      if (ab != 31 && falls >= ab && !ser_frame_n) abort_req = 1'b1;
      wd++;
    end
    abort_req = 1'b0;
    check(done_cnt == dc + 1, "R7 one done pulse", done_cnt - dc, 1);
    if (ab == 31) begin
      check(last_word == exp_word, "R2 word", int'(last_word), int'(exp_word));
      check(last_falls == 16, "R4 falling edges", last_falls, 16);
      check(last_ab == 0, "R7 aborted flag", last_ab, 0);
      if (v[19]) check(last_low8 == BGAP, "R5 split pause", last_low8, BGAP);
      else       check(last_low8 == HALF, "R5 no split pause", last_low8, HALF);
    end else begin
      check(last_falls == ab, "R6 edges before abort", last_falls, ab);
      check(last_word == 16'((int'(exp_word)) >> (16 - ab)), "R6 partial word",
            int'(last_word), (int'(exp_word)) >> (16 - ab));
      check(last_ab == 1, "R6 aborted flag", last_ab, 1);
    end
    check(!req_ready, "R8 ready low at done", int'(req_ready), 0);
    n = 0;
    while (!req_ready && n < 100) begin
      @(negedge clk); #1; n++;
    end
    check(n == GAP, "R8 ready delay", n, GAP);
  endtask

  initial begin
    int dc;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(ser_frame_n && !ser_clk && !ser_data && !done && !done_aborted,
          "R1 reset outputs", {ser_frame_n, ser_clk, ser_data, done, done_aborted}, 5'b10000);
    rst = 1'b0;
    @(negedge clk); #1;
    check(ser_frame_n && !ser_clk && !ser_data && req_ready && !done,
          "R1 after reset", {ser_frame_n, ser_clk, ser_data, req_ready, done}, 5'b10010);
    // R10 abort while idle
    dc = done_cnt;
    abort_req = 1'b1;
    repeat (6) begin
      @(negedge clk); #1;
      check(ser_frame_n && !ser_clk && !ser_data && req_ready, "R10 idle abort lines",
            {ser_frame_n, ser_clk, ser_data, req_ready}, 4'b1001);
    end
    abort_req = 1'b0;
    check(done_cnt == dc, "R10 no done", done_cnt - dc, 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    check(viol_data == 0, "R3 data change off rise", viol_data, 0);
    check(min_setup >= SETUP, "R3 setup time", min_setup, SETUP);
    check(viol_phase == 0, "R4 phase length", viol_phase, 0);
    check(viol_ready == 0, "R8 ready during frame", viol_ready, 0);
    check(viol_gap == 0, "R8 frame gap", viol_gap, 0);
    check(viol_idle == 0, "R9 data idle low", viol_idle, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule